// File: doc/BRIEF.md
# Interrupt Expander with Register Access

This block merges a set of slow, asynchronous board-level interrupt lines into a single active-low, level-type request for a host processor. Each line is brought into the clock domain through a short flop chain and then latched into a sticky pending word. A mask word decides which pending bits may pull the shared request low.

Software reaches the block over a plain synchronous halfword register bus with a byte address, a write strobe, write data and registered read data. Through it, software reads the pending word and rewrites the mask. It clears pending bits by raising chosen bits of a separate clear word and later dropping them again. Two constant identity words let a driver confirm the block is present before it enables anything, and a constant revision word reports the logic version.

Top module: `irq_expander`

## Requirements
- R1: After reset the pending word reads 0x0000, the mask word reads 0xFFFF (every line disabled), the clear word reads 0x0000 and `irq_n_o` is 1.
- R2: Byte offset 0x40 reads 0xAAAA and byte offset 0x48 reads 0x5555.
- R3: Byte offset 0x00 reads the revision constant given by parameter `REVISION` (default 0x0103).
- R4: Read data appears on `rd_data_o` one clock edge after the address is presented; any offset other than 0x00, 0x28, 0x30, 0x38, 0x40 and 0x48 reads 0x0000.
- R5: Pending bit n (byte offset 0x28, bit n for line n) becomes 1 on the third rising edge after line n goes high, and stays 1 after the line falls until it is cleared.
- R6: Mask bit n = 1 blocks pending bit n; `irq_n_o` is 0 exactly when some pending bit has its mask bit at 0, and it follows mask writes in the same cycle the mask changes.
- R7: Writing a 1 to bit n of the clear word (byte offset 0x30) clears pending bit n at that write edge and keeps it cleared while the clear bit stays 1, even with the line high; other pending bits are untouched, and writing 0 lets the bit latch again.
- R8: Writes to the pending word, the identity words and the revision word leave their read values unchanged.
- R9: The mask word at byte offset 0x38 and the clear word at byte offset 0x30 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Asynchronous interrupt lines, active high |
| addr_i | input | 12 | Byte address within the 4 KB window |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Registered read data |
| irq_n_o | output | 1 | Combined interrupt request, active low |

## Verification
The latching path is driven with a single line rising against an unmasked mask, sampling the request on both sides of the third edge to pin down the synchronizer depth, then with the line dropped to show the bit is sticky. Two lines pending at once, with one of them cleared while it is still high, separate a per-bit clear from a whole-word clear and show that clear beats set. Mask writes over a standing pending bit tell gating apart from latching, while writes aimed at read-only offsets and reads of unmapped offsets following a non-zero read expose any stray write decode or a read path that fails to return zero.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_REV,
      SEL_PEND,
      SEL_CLR,
      SEL_MASK,
      SEL_ID_A,
      SEL_ID_B
   } reg_sel_e;

   localparam logic [15:0] ID_WORD_A = 16'hAAAA;
   localparam logic [15:0] ID_WORD_B = 16'h5555;

endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_o = async_i;
      end else begin : g_chain
         logic [WIDTH-1:0] chain_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
            end else begin
               chain_q[0] <= async_i;
               for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
            end
         end
         assign sync_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/irqx_decode.sv
module irqx_decode
   import irqx_pkg::*;
#(
   parameter int          ADDR_W   = 12,
   parameter logic [11:0] OFF_REV  = 12'h000,
   parameter logic [11:0] OFF_PEND = 12'h028,
   parameter logic [11:0] OFF_CLR  = 12'h030,
   parameter logic [11:0] OFF_MASK = 12'h038,
   parameter logic [11:0] OFF_ID_A = 12'h040,
   parameter logic [11:0] OFF_ID_B = 12'h048
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o
);

   localparam int OFF_W = 12;

   logic [OFF_W-1:0] off;
   assign off = OFF_W'(addr_i);

   always_comb begin
      if      (off == OFF_REV)  sel_o = SEL_REV;
      else if (off == OFF_PEND) sel_o = SEL_PEND;
      else if (off == OFF_CLR)  sel_o = SEL_CLR;
      else if (off == OFF_MASK) sel_o = SEL_MASK;
      else if (off == OFF_ID_A) sel_o = SEL_ID_A;
      else if (off == OFF_ID_B) sel_o = SEL_ID_B;
      else                      sel_o = SEL_NONE;
   end

endmodule

// File: rtl/irqx_regfile.sv
module irqx_regfile
   import irqx_pkg::*;
#(
   parameter int NSRC   = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  reg_sel_e          sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [NSRC-1:0]   set_i,
   output logic [NSRC-1:0]   pend_o,
   output logic [NSRC-1:0]   mask_o,
   output logic [NSRC-1:0]   clr_o
);

   logic [NSRC-1:0] pend_q, mask_q, clr_q;
   logic [NSRC-1:0] clr_eff;
   logic            clr_wr, mask_wr;

   assign clr_wr  = wr_en_i && (sel_i == SEL_CLR);
   assign mask_wr = wr_en_i && (sel_i == SEL_MASK);
   // a clear written this cycle already wins over a set arriving this cycle
   assign clr_eff = clr_wr ? wr_data_i[NSRC-1:0] : clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '1;
         clr_q  <= '0;
      end else begin
         pend_q <= (pend_q | set_i) & ~clr_eff;
         if (mask_wr) mask_q <= wr_data_i[NSRC-1:0];
         if (clr_wr)  clr_q  <= wr_data_i[NSRC-1:0];
      end
   end

   assign pend_o = pend_q;
   assign mask_o = mask_q;
   assign clr_o  = clr_q;

   // R7: a raised clear bit never coexists with its pending bit
   assert_clear_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & clr_q) == '0);

   // R5: an uncleared synchronized line is latched at the next edge
   assert_set_latches_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(set_i & ~clr_eff)) == $past(set_i & ~clr_eff)));

   // R1: reset values are visible at the first edge after reset release
   assert_reset_values_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (mask_q == '1 && pend_q == '0 && clr_q == '0));

endmodule

// File: rtl/irqx_readmux.sv
module irqx_readmux
   import irqx_pkg::*;
#(
   parameter int          NSRC     = 16,
   parameter int          DATA_W   = 16,
   parameter logic [15:0] REVISION = 16'h0103
) (
   input  logic              clk,
   input  logic              rst_n,
   input  reg_sel_e          sel_i,
   input  logic [NSRC-1:0]   pend_i,
   input  logic [NSRC-1:0]   mask_i,
   input  logic [NSRC-1:0]   clr_i,
   output logic [DATA_W-1:0] rd_data_o
);

   logic [DATA_W-1:0] rd_d, rd_q;
   logic              hit;

   assign hit = (sel_i != SEL_NONE);

   always_comb begin
      case (sel_i)
         SEL_REV:  rd_d = DATA_W'(REVISION);
         SEL_PEND: rd_d = DATA_W'(pend_i);
         SEL_CLR:  rd_d = DATA_W'(clr_i);
         SEL_MASK: rd_d = DATA_W'(mask_i);
         SEL_ID_A: rd_d = DATA_W'(ID_WORD_A);
         SEL_ID_B: rd_d = DATA_W'(ID_WORD_B);
         default:  rd_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= rd_d;
   end

   assign rd_data_o = rd_q;

   // R4: an unmapped address yields zero one edge later
   assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> (rd_data_o == '0));

endmodule

// File: rtl/irq_expander.sv
module irq_expander
   import irqx_pkg::*;
#(
   parameter int          NSRC        = 16,
   parameter int          DATA_W      = 16,
   parameter int          ADDR_W      = 12,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] REVISION    = 16'h0103
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_n_o
);

   localparam logic [11:0] OFF_REV  = 12'h000;
   localparam logic [11:0] OFF_PEND = 12'h028;
   localparam logic [11:0] OFF_CLR  = 12'h030;
   localparam logic [11:0] OFF_MASK = 12'h038;
   localparam logic [11:0] OFF_ID_A = 12'h040;
   localparam logic [11:0] OFF_ID_B = 12'h048;

   generate
      if (NSRC < 1 || NSRC > DATA_W) begin : g_bad_nsrc
         $error("NSRC must lie between 1 and DATA_W");
      end
      if (DATA_W != 16) begin : g_bad_width
         $error("register words are halfwords");
      end
      if (ADDR_W < 7 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must cover the map and stay inside 4 KB");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic [NSRC-1:0] src_sync;
   logic [NSRC-1:0] pend, mask, clr;
   reg_sel_e        sel;

   irqx_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (src_i),
      .sync_o  (src_sync)
   );

   irqx_decode #(
      .ADDR_W   (ADDR_W),
      .OFF_REV  (OFF_REV),
      .OFF_PEND (OFF_PEND),
      .OFF_CLR  (OFF_CLR),
      .OFF_MASK (OFF_MASK),
      .OFF_ID_A (OFF_ID_A),
      .OFF_ID_B (OFF_ID_B)
   ) u_decode (
      .addr_i (addr_i),
      .sel_o  (sel)
   );

   irqx_regfile #(.NSRC(NSRC), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .sel_i     (sel),
      .wr_data_i (wr_data_i),
      .set_i     (src_sync),
      .pend_o    (pend),
      .mask_o    (mask),
      .clr_o     (clr)
   );

   irqx_readmux #(.NSRC(NSRC), .DATA_W(DATA_W), .REVISION(REVISION)) u_read (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (sel),
      .pend_i    (pend),
      .mask_i    (mask),
      .clr_i     (clr),
      .rd_data_o (rd_data_o)
   );

   assign irq_n_o = ~|(pend & ~mask);

   // R6: the request only asserts when pending or mask state has moved
   assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n_o) |-> (pend != $past(pend) || mask != $past(mask)));

endmodule

// File: tb/irq_expander_tb.sv
module irq_expander_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] src;
   logic [11:0] addr;
   logic        we;
   logic [15:0] wd;
   logic [15:0] rd;
   logic        irq_n;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #5 clk = ~clk;

   irq_expander dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src),
      .addr_i    (addr),
      .wr_en_i   (we),
      .wr_data_i (wd),
      .rd_data_o (rd),
      .irq_n_o   (irq_n)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wd = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rdw(input logic [11:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a; we = 1'b0;
      @(negedge clk);
      d = rd;
   endtask

   task automatic t_reset;
      logic [15:0] v;
      chk("R1 irq_n", {15'd0, irq_n}, 16'h0001);
      rdw(12'h028, v); chk("R1 pending", v, 16'h0000);
      rdw(12'h038, v); chk("R1 mask", v, 16'hFFFF);
      rdw(12'h030, v); chk("R1 clear", v, 16'h0000);
   endtask

   task automatic t_ident;
      logic [15:0] v;
      rdw(12'h040, v); chk("R2 id A", v, 16'hAAAA);
      rdw(12'h048, v); chk("R2 id B", v, 16'h5555);
      rdw(12'h000, v); chk("R3 revision", v, 16'h0103);
   endtask

   task automatic t_unmapped;
      logic [15:0] v;
      rdw(12'h040, v);
      rdw(12'h002, v); chk("R4 unmapped 0x002", v, 16'h0000);
      rdw(12'h048, v);
      rdw(12'h02A, v); chk("R4 unmapped 0x02A", v, 16'h0000);
      rdw(12'h040, v);
      rdw(12'hFFE, v); chk("R4 unmapped 0xFFE", v, 16'h0000);
      // latency: address switched at a negedge shows only after the next edge
      @(negedge clk); addr = 12'h048;
      #2 chk("R4 latency before edge", rd, 16'h0000);
      @(negedge clk); chk("R4 latency after edge", rd, 16'h5555);
   endtask

   task automatic t_init_seq;
      logic [15:0] v;
      wr(12'h038, 16'h0000);
      wr(12'h030, 16'hFFFF);
      wr(12'h030, 16'h0000);
      wr(12'h038, 16'h001F);
      rdw(12'h038, v); chk("R9 mask readback", v, 16'h001F);
      wr(12'h038, 16'hFFF7);
   endtask

   task automatic t_latch;
      logic [15:0] v;
      @(negedge clk); src[3] = 1'b1;
      @(negedge clk);
      @(negedge clk); chk("R5 not yet after two edges", {15'd0, irq_n}, 16'h0001);
      @(negedge clk); chk("R5 set on third edge", {15'd0, irq_n}, 16'h0000);
      src[3] = 1'b0;
      repeat (5) @(negedge clk);
      rdw(12'h028, v); chk("R5 sticky after line falls", v, 16'h0008);
   endtask

   task automatic t_mask;
      wr(12'h038, 16'hFFFF);
      chk("R6 masked bit blocks", {15'd0, irq_n}, 16'h0001);
      wr(12'h038, 16'hFFF7);
      chk("R6 unmasked bit asserts", {15'd0, irq_n}, 16'h0000);
      wr(12'h038, 16'h0008);
      chk("R6 other bits unmasked, bit3 masked", {15'd0, irq_n}, 16'h0001);
      wr(12'h038, 16'h0000);
   endtask

   task automatic t_clear;
      logic [15:0] v;
      @(negedge clk); src[3] = 1'b1; src[0] = 1'b1;
      repeat (4) @(negedge clk);
      rdw(12'h028, v); chk("R5 two lines pending", v, 16'h0009);
      wr(12'h030, 16'h0008);
      rdw(12'h028, v); chk("R7 selective clear", v, 16'h0001);
      rdw(12'h030, v); chk("R9 clear readback", v, 16'h0008);
      repeat (4) @(negedge clk);
      rdw(12'h028, v); chk("R7 clear beats high line", v, 16'h0001);
      wr(12'h030, 16'h0000);
      rdw(12'h028, v); chk("R7 relatch after release", v, 16'h0009);
      src[3] = 1'b0; src[0] = 1'b0;
      repeat (3) @(negedge clk);
      wr(12'h030, 16'hFFFF);
      wr(12'h030, 16'h0000);
      rdw(12'h028, v); chk("R7 clear all", v, 16'h0000);
      chk("R6 idle after clear", {15'd0, irq_n}, 16'h0001);
   endtask

   task automatic t_readonly;
      logic [15:0] v;
      wr(12'h028, 16'hFFFF);
      rdw(12'h028, v); chk("R8 pending unwritable", v, 16'h0000);
      chk("R8 irq stays idle", {15'd0, irq_n}, 16'h0001);
      wr(12'h040, 16'h1234);
      rdw(12'h040, v); chk("R8 id A unwritable", v, 16'hAAAA);
      wr(12'h048, 16'h0000);
      rdw(12'h048, v); chk("R8 id B unwritable", v, 16'h5555);
      wr(12'h000, 16'hFFFF);
      rdw(12'h000, v); chk("R8 revision unwritable", v, 16'h0103);
   endtask

   initial begin
      rst_n = 1'b0; src = '0; addr = '0; we = 1'b0; wd = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ident();
      t_unmapped();
      t_init_seq();
      t_latch();
      t_mask();
      t_clear();
      t_readonly();
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule